// File: doc/BRIEF.md
# Sixteen-Bit Multi-Unit Arithmetic Logic Unit

This block is a purely combinational arithmetic-logic unit for a 16-bit datapath. It takes two source words and an 8-bit immediate. A selection stage can put the zero-extended immediate in place of the second source. A conditional inverter then complements that operand and the carry-in when a subtraction is requested. The first source and the prepared second operand go to four units that work side by side. A ripple adder, a bitwise logic unit, a one-position shift/rotate-through-carry unit and a left barrel rotator each compute a result. An operation code picks one of those results.

Along with the 16-bit result, the block gives four status bits: carry, zero, negative and signed overflow. Storing the flags is left to the surrounding core. For the rotate-through-carry operations and for carry-chained arithmetic, the stored carry is fed back on the carry-in pin. All widths are parameters. The word width must be a power of two so that the barrel rotator's amount field and its stage count follow from it.

Top module: `alu16_core`

## Requirements
- R1: When `use_imm` is 1 the second operand is `imm` zero-extended to the word width and `src_b` has no effect on any output; when 0 the second operand is `src_b`.
- R2: Op code 0 (add) gives result = src_a + op2 + carry_in modulo 2^16, with `flag_c` the carry out of bit 15.
- R3: Op code 1 (subtract) inverts op2 and carry_in before the adder, so result = src_a - op2 - carry_in modulo 2^16 and `flag_c` is 1 exactly when no borrow occurs.
- R4: Op codes 2, 3, 4, 5 give src_a AND op2, src_a OR op2, src_a XOR op2 and NOT src_a respectively, with `flag_c` = 0.
- R5: Op codes 6 (shift left), 7 (logical shift right) and 8 (arithmetic shift right, bit 15 kept) move src_a one position, and `flag_c` is the bit shifted out (bit 15 for left, bit 0 for right).
- R6: Op codes 9 and 10 rotate src_a one position left or right through carry: `carry_in` enters the vacated end and `flag_c` is the bit shifted out.
- R7: Op code 11 rotates src_a left by op2[3:0] positions, taken before any inversion; higher op2 bits have no effect and `flag_c` = 0.
- R8: Op codes 12 to 15 return src_a unchanged with `flag_c` = 0 and `flag_v` = 0.
- R9: `flag_z` is 1 exactly when the result is all zeros, and `flag_n` equals result bit 15, for every op code.
- R10: `flag_v` is 1 for add or subtract only when both adder inputs share a sign that differs from the result's sign; it is 0 for all other op codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 16 | First source operand |
| src_b | input | 16 | Second source operand |
| imm | input | 8 | Immediate constant |
| use_imm | input | 1 | Substitute the zero-extended immediate for src_b |
| carry_in | input | 1 | Incoming carry for add, subtract and rotate-through-carry |
| op | input | 4 | Operation code |
| result | output | 16 | Selected unit result |
| flag_c | output | 1 | Carry / no-borrow / shifted-out bit |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 15 |
| flag_v | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks evaluate only when every input is a known 0 or 1. They assume that the inputs stay constant long enough for the combinational paths to settle before the checks sample them. The bench therefore changes inputs only on the falling clock edge and reads the outputs one nanosecond later. Every input field is driven with defined values from time zero, so no check sees an undriven operand. The subtraction-carry check covers only the case where carry-in is 0. The bench supplies such cases alongside the borrow-in cases it checks directly.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_NOT  = 4'd5,
      OP_SHL  = 4'd6,
      OP_SHR  = 4'd7,
      OP_SAR  = 4'd8,
      OP_RCL  = 4'd9,
      OP_RCR  = 4'd10,
      OP_ROTL = 4'd11
   } alu_op_e;

   localparam int OP_W = 4;

endpackage

// File: rtl/alu16_operand.sv
module alu16_operand #(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8
) (
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              invert,
   input  logic              carry_in,
   output logic [DATA_W-1:0] sel_raw,
   output logic [DATA_W-1:0] opnd,
   output logic              cin_eff
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm};
      end else begin : g_nopad
         assign imm_ext = imm[DATA_W-1:0];
      end
   endgenerate

   assign sel_raw = use_imm ? imm_ext : src_b;
   assign opnd    = invert ? ~sel_raw : sel_raw;
   assign cin_eff = invert ? ~carry_in : carry_in;

   always_comb begin
      if (!$isunknown({use_imm, imm}) && use_imm)
         AST_IMM_ZERO_EXT: assert (sel_raw[DATA_W-1:IMM_W] == '0 || PAD_W == 0); // R1
   end
endmodule

// File: rtl/alu16_adder.sv
module alu16_adder #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   logic [DATA_W:0] chain;

   assign chain[0] = cin;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_fa
         assign sum[i]      = a[i] ^ b[i] ^ chain[i];
         assign chain[i+1]  = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
      end
   endgenerate

   assign cout = chain[DATA_W];

   always_comb begin
      if (!$isunknown({a, b, cin}))
         AST_ADDER_TOTAL: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin))); // R2
   end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [3:0]        op,
   input  logic              cin,
   output logic [DATA_W-1:0] y,
   output logic              cout
);
   import alu16_pkg::*;

   always_comb begin
      y    = a;
      cout = 1'b0;
      case (op)
         OP_SHL: begin y = {a[DATA_W-2:0], 1'b0};        cout = a[DATA_W-1]; end
         OP_SHR: begin y = {1'b0, a[DATA_W-1:1]};        cout = a[0];        end
         OP_SAR: begin y = {a[DATA_W-1], a[DATA_W-1:1]}; cout = a[0];        end
         OP_RCL: begin y = {a[DATA_W-2:0], cin};         cout = a[DATA_W-1]; end
         OP_RCR: begin y = {cin, a[DATA_W-1:1]};         cout = a[0];        end
         default: ;
      endcase
   end

   always_comb begin
      if (!$isunknown({a, op, cin}) && (op == OP_RCL || op == OP_RCR))
         AST_RC_KEEPS_BITS: assert ($countones({cout, y}) == $countones({cin, a})); // R6
   end
endmodule

// File: rtl/alu16_barrel.sv
module alu16_barrel #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0]         a,
   input  logic [$clog2(DATA_W)-1:0] amt,
   output logic [DATA_W-1:0]         y
);
   localparam int STAGES = $clog2(DATA_W);

   logic [DATA_W-1:0] stage [STAGES+1];

   assign stage[0] = a;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stage[k+1] = amt[k]
            ? {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]}
            : stage[k];
      end
   endgenerate

   assign y = stage[STAGES];

   always_comb begin
      if (!$isunknown({a, amt}))
         AST_ROT_POPCOUNT: assert ($countones(y) == $countones(a)); // R7
   end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              carry_in,
   input  logic [3:0]        op,
   output logic [DATA_W-1:0] result,
   output logic              flag_c,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_v
);
   import alu16_pkg::*;

   localparam int ROT_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;

   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("alu16_core: DATA_W must be a power of two of at least 4");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("alu16_core: IMM_W must lie between 1 and DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] sel_raw, opnd, sum, shf_y, rot_y;
   logic              cin_eff, add_c, shf_c, is_sub, is_arith;

   assign is_sub   = (op == OP_SUB);
   assign is_arith = (op == OP_ADD) || is_sub;

   alu16_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
      .src_b(src_b), .imm(imm), .use_imm(use_imm), .invert(is_sub),
      .carry_in(carry_in), .sel_raw(sel_raw), .opnd(opnd), .cin_eff(cin_eff)
   );

   alu16_adder #(.DATA_W(DATA_W)) u_add (
      .a(src_a), .b(opnd), .cin(cin_eff), .sum(sum), .cout(add_c)
   );

   alu16_shift #(.DATA_W(DATA_W)) u_shf (
      .a(src_a), .op(op), .cin(carry_in), .y(shf_y), .cout(shf_c)
   );

   alu16_barrel #(.DATA_W(DATA_W)) u_rot (
      .a(src_a), .amt(sel_raw[ROT_W-1:0]), .y(rot_y)
   );

   always_comb begin
      result = src_a;
      flag_c = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin result = sum; flag_c = add_c; end
         OP_AND:  result = src_a & opnd;
         OP_OR:   result = src_a | opnd;
         OP_XOR:  result = src_a ^ opnd;
         OP_NOT:  result = ~src_a;
         OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
            result = shf_y;
            flag_c = shf_c;
         end
         OP_ROTL: result = rot_y;
         default: ;
      endcase
   end

   assign flag_z = (result == '0);
   assign flag_n = result[MSB];
   assign flag_v = is_arith && (src_a[MSB] == opnd[MSB]) && (result[MSB] != src_a[MSB]);

   always_comb begin
      if (!$isunknown({src_a, src_b, imm, use_imm, carry_in, op})) begin
         if (op > 4'd11)
            AST_UNDEF_PASS: assert (result == src_a && !flag_c && !flag_v); // R8
         if (is_sub && !carry_in)
            AST_SUB_NO_BORROW: assert (flag_c == (src_a >= sel_raw)); // R3
         if (!is_arith)
            AST_NO_OVERFLOW: assert (!flag_v); // R10
         AST_ZERO_SIGN: assert (flag_z == ($countones(result) == 0)); // R9
      end
   end
endmodule

// File: tb/alu16_core_bench.sv
`timescale 1ns/1ps
module alu16_core_bench;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] src_a = '0, src_b = '0;
   logic [7:0]   imm = '0;
   logic         use_imm = 1'b0, carry_in = 1'b0;
   logic [3:0]   op = '0;
   logic [W-1:0] result;
   logic         flag_c, flag_z, flag_n, flag_v;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   alu16_core u_alu16_core (
      .src_a(src_a), .src_b(src_b), .imm(imm), .use_imm(use_imm),
      .carry_in(carry_in), .op(op), .result(result),
      .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [7:0] k,
                        input logic ui, input logic ci, input logic [3:0] o);
      @(negedge clk);
      src_a = a; src_b = b; imm = k; use_imm = ui; carry_in = ci; op = o;
      #1;
   endtask

   // expects {result, c, v}; z and n follow from result (R9)
   task automatic expect_all(input string req, input logic [W-1:0] r, input logic c, input logic v);
      chk({req, " result"}, 32'(result), 32'(r));
      chk({req, " carry"}, 32'(flag_c), 32'(c));
      chk({req, " overflow R10"}, 32'(flag_v), 32'(v));
      chk("R9 zero", 32'(flag_z), 32'(r == '0));
      chk("R9 negative", 32'(flag_n), 32'(r[W-1]));
   endtask

   task automatic t_reset_state;
      drive('0, '0, '0, 1'b0, 1'b0, 4'd0);
      expect_all("R2 idle add", 16'h0000, 1'b0, 1'b0);
   endtask

   task automatic t_add;
      drive(16'h1234, 16'h0FF1, 8'h00, 1'b0, 1'b0, 4'd0);
      expect_all("R2 add", 16'h2225, 1'b0, 1'b0);
      drive(16'hFFFF, 16'h0000, 8'h00, 1'b0, 1'b1, 4'd0);
      expect_all("R2 add carry-in wrap", 16'h0000, 1'b1, 1'b0);
      drive(16'h7FFF, 16'h0001, 8'h00, 1'b0, 1'b0, 4'd0);
      expect_all("R10 add overflow", 16'h8000, 1'b0, 1'b1);
      drive(16'h8000, 16'h8000, 8'h00, 1'b0, 1'b0, 4'd0);
      expect_all("R10 neg overflow", 16'h0000, 1'b1, 1'b1);
   endtask

   task automatic t_sub;
      drive(16'h0005, 16'h0003, 8'h00, 1'b0, 1'b0, 4'd1);
      expect_all("R3 sub", 16'h0002, 1'b1, 1'b0);
      drive(16'h0003, 16'h0005, 8'h00, 1'b0, 1'b0, 4'd1);
      expect_all("R3 sub borrow", 16'hFFFE, 1'b0, 1'b0);
      drive(16'h0005, 16'h0005, 8'h00, 1'b0, 1'b1, 4'd1);
      expect_all("R3 sub borrow-in", 16'hFFFF, 1'b0, 1'b0);
      drive(16'h8000, 16'h0001, 8'h00, 1'b0, 1'b0, 4'd1);
      expect_all("R10 sub overflow", 16'h7FFF, 1'b1, 1'b1);
   endtask

   task automatic t_imm;
      drive(16'h1000, 16'hABCD, 8'hF0, 1'b1, 1'b0, 4'd0);
      expect_all("R1 imm add zero-ext", 16'h10F0, 1'b0, 1'b0);
      drive(16'h1000, 16'h5555, 8'hF0, 1'b1, 1'b0, 4'd0);
      expect_all("R1 src_b ignored", 16'h10F0, 1'b0, 1'b0);
      drive(16'h0100, 16'h0000, 8'h01, 1'b1, 1'b0, 4'd1);
      expect_all("R1 imm sub", 16'h00FF, 1'b1, 1'b0);
      drive(16'hFFFF, 16'h0000, 8'h0F, 1'b1, 1'b0, 4'd2);
      expect_all("R1 imm and", 16'h000F, 1'b0, 1'b0);
   endtask

   task automatic t_logic;
      drive(16'hF0F0, 16'hFF00, 8'h00, 1'b0, 1'b1, 4'd2);
      expect_all("R4 and", 16'hF000, 1'b0, 1'b0);
      drive(16'hF0F0, 16'h0F00, 8'h00, 1'b0, 1'b1, 4'd3);
      expect_all("R4 or", 16'hFFF0, 1'b0, 1'b0);
      drive(16'hF0F0, 16'hFF00, 8'h00, 1'b0, 1'b0, 4'd4);
      expect_all("R4 xor", 16'h0FF0, 1'b0, 1'b0);
      drive(16'hFFFF, 16'h1234, 8'h00, 1'b0, 1'b1, 4'd5);
      expect_all("R4 not", 16'h0000, 1'b0, 1'b0);
   endtask

   task automatic t_shift;
      drive(16'h8001, 16'h0000, 8'h00, 1'b0, 1'b0, 4'd6);
      expect_all("R5 shl", 16'h0002, 1'b1, 1'b0);
      drive(16'h8001, 16'h0000, 8'h00, 1'b0, 1'b1, 4'd7);
      expect_all("R5 shr", 16'h4000, 1'b1, 1'b0);
      drive(16'h8002, 16'h0000, 8'h00, 1'b0, 1'b0, 4'd8);
      expect_all("R5 sar", 16'hC001, 1'b0, 1'b0);
   endtask

   task automatic t_rotc;
      drive(16'h8000, 16'h0000, 8'h00, 1'b0, 1'b1, 4'd9);
      expect_all("R6 rcl", 16'h0001, 1'b1, 1'b0);
      drive(16'h4000, 16'h0000, 8'h00, 1'b0, 1'b0, 4'd9);
      expect_all("R6 rcl no cin", 16'h8000, 1'b0, 1'b0);
      drive(16'h0001, 16'h0000, 8'h00, 1'b0, 1'b1, 4'd10);
      expect_all("R6 rcr", 16'h8000, 1'b1, 1'b0);
   endtask

   task automatic t_barrel;
      for (int s = 0; s < 16; s++) begin
         logic [W-1:0] a;
         a = 16'h8421 ^ 16'(s);
         drive(a, 16'hFFF0 | 16'(s), 8'h00, 1'b0, 1'b1, 4'd11);
         expect_all("R7 rotl", (a << s) | (a >> ((16 - s) % 16)), 1'b0, 1'b0);
      end
      drive(16'h0001, 16'h0000, 8'h3F, 1'b1, 1'b0, 4'd11);
      expect_all("R7 rotl imm amount", 16'h8000, 1'b0, 1'b0);
   endtask

   task automatic t_undef;
      for (int o = 12; o < 16; o++) begin
         drive(16'hA5C3, 16'hFFFF, 8'hFF, 1'b0, 1'b1, 4'(o));
         expect_all("R8 undefined", 16'hA5C3, 1'b0, 1'b0);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_imm();
      t_logic();
      t_shift();
      t_rotc();
      t_barrel();
      t_undef();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule